// File: doc/BRIEF.md
# Vectored Interrupt Entry Controller

This block sits beside an 8-bit microcontroller core. It takes the interrupt requests of eleven peripheral sources and runs the hardware side of interrupt entry and return. The sources are the compare, overflow and capture events of three timers and an SPI transfer-complete event. Each source reaches the block as a pending flag and an enable bit.

The block holds the global interrupt enable. When that enable is set and at least one source is both pending and enabled, the block takes the winning source. It then:

- clears the global enable,
- writes the 16-bit return address to a byte-wide stack memory,
- clears the serviced source's pending flag through a one-cycle clear strobe,
- loads the source's vector into the program counter.

A return request from the core reads the address back from the stack, reloads the program counter and sets the global enable again. While either sequence runs, a busy output stalls the core's fetch.

Top module: `irq_entry_ctrl`

## Requirements
- R1: A source is taken only when its pending flag and its enable bit are both 1. A flag without its enable, or an enable without its flag, never starts an entry.
- R2: An entry starts only while the global enable (gie_o) is 1. Entry clears the global enable, and gie_o reads 0 from the first entry cycle onward.
- R3: Source input bit i (0..10) owns vector slot 9+i. The bit order is:
  - bits 0..2: timer2 compare A, compare B, overflow;
  - bits 3..6: timer1 capture, compare A, compare B, overflow;
  - bits 7..9: timer0 compare A, compare B, overflow;
  - bit 10: SPI transfer complete.
  When several sources request at once, the lowest slot number wins.
- R4: The address placed on pc_o at entry is the slot number shifted left by one bit.
- R5: Entry writes the return address to the stack in two steps. The first write puts the low byte at the stack pointer. The second write puts the high byte at the stack pointer minus 1. The stack pointer decrements after each write.
- R6: During each entry, flag_clr_o pulses for exactly one cycle, with only the serviced source's bit set.
- R7: A return (reti_i) reads the stack pointer plus 1 to get the high byte, then the next address up to get the low byte. Stack reads have one cycle of latency. The return loads {high, low} onto pc_o, sets the global enable, and leaves the stack pointer where it was before the matching entry.
- R8: Entry and return each hold busy_o high for exactly 4 cycles. pc_load_o pulses once, in the last of those cycles.
- R9: After reset: busy_o is 0, gie_o is 0, no stack write or program counter load is issued, and the stack pointer equals SP_INIT.
- R10: While the block is idle, sei_i sets the global enable and cli_i clears it. A return request has priority over a new entry in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_flag_i | input | 11 | Pending flags, bit i maps to slot 9+i |
| src_en_i | input | 11 | Per-source enable bits |
| sei_i | input | 1 | Set the global enable (idle only) |
| cli_i | input | 1 | Clear the global enable (idle only) |
| reti_i | input | 1 | Start the return-from-interrupt sequence |
| ret_pc_i | input | 16 | Address to resume at, captured on entry |
| busy_o | output | 1 | High while a sequence runs; the core stalls fetch |
| gie_o | output | 1 | Global interrupt enable |
| flag_clr_o | output | 11 | One-cycle clear strobe for the serviced flag |
| pc_load_o | output | 1 | Load pc_o into the program counter |
| pc_o | output | 16 | Vector or restored return address |
| stk_addr_o | output | 16 | Stack memory address |
| stk_wdata_o | output | 8 | Stack write data |
| stk_we_o | output | 1 | Stack write enable |
| stk_rdata_i | input | 8 | Stack read data, one cycle after the address |

## Verification
The assertions take three things for granted about the inputs:
- sei_i, cli_i and reti_i are raised only while busy_o is low;
- a return is issued only after a matching entry;
- the stack memory returns data exactly one cycle after the address is presented.

The stimulus keeps to this. It pulses the control inputs only between sequences. It clears every enable before a return, so that no new entry races the reload. It uses a stack model with a registered read port, and the model drops a pending flag on the edge after its clear strobe, as a peripheral would.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PUSH_LO,
    ST_PUSH_HI,
    ST_CLR,
    ST_JMP_V,
    ST_POP_HI,
    ST_POP_LO,
    ST_CAP_LO,
    ST_JMP_R
  } seq_state_e;
endpackage

// File: rtl/irq_entry_arb.sv
module irq_entry_arb #(
  parameter int N_SRC = 11,
  localparam int IW = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] req_i,
  output logic [N_SRC-1:0] grant_o,
  output logic [IW-1:0]    idx_o,
  output logic             any_o
);
  logic [N_SRC:0] seen;
  assign seen[0] = 1'b0;

  // lowest index wins
  for (genvar i = 0; i < N_SRC; i++) begin : g_chain
    assign grant_o[i]  = req_i[i] & ~seen[i];
    assign seen[i+1]   = seen[i] | req_i[i];
  end

  assign any_o = seen[N_SRC];

  always_comb begin
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (grant_o[i]) idx_o = IW'(i);
  end
endmodule

// File: rtl/irq_entry_sp.sv
module irq_entry_sp #(
  parameter int          AW      = 16,
  parameter logic [AW-1:0] SP_INIT = 16'h10FF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dec_i,
  input  logic          inc_i,
  output logic [AW-1:0] sp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sp_o <= SP_INIT;
    else if (dec_i) sp_o <= sp_o - AW'(1);
    else if (inc_i) sp_o <= sp_o + AW'(1);
  end
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
#(
  parameter int            N_SRC     = 11,
  parameter int            BASE_SLOT = 9,
  parameter int            DW        = 8,
  parameter int            AW        = 2 * DW,
  parameter logic [AW-1:0] SP_INIT   = 16'h10FF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_flag_i,
  input  logic [N_SRC-1:0] src_en_i,
  input  logic             sei_i,
  input  logic             cli_i,
  input  logic             reti_i,
  input  logic [AW-1:0]    ret_pc_i,
  output logic             busy_o,
  output logic             gie_o,
  output logic [N_SRC-1:0] flag_clr_o,
  output logic             pc_load_o,
  output logic [AW-1:0]    pc_o,
  output logic [AW-1:0]    stk_addr_o,
  output logic [DW-1:0]    stk_wdata_o,
  output logic             stk_we_o,
  input  logic [DW-1:0]    stk_rdata_i
);
  localparam int IW = $clog2(N_SRC);

  seq_state_e       state_q, state_d;
  logic [N_SRC-1:0] req, grant, grant_q;
  logic [IW-1:0]    gidx;
  logic             any, accept, start_ret, push, pop;
  logic             gie_q;
  logic [AW-1:0]    ret_q, vec_q, vec_d, sp;
  logic [DW-1:0]    hi_q, lo_q;

  assign req = src_flag_i & src_en_i;

  irq_entry_arb #(.N_SRC(N_SRC)) u_arb (
    .req_i   (req),
    .grant_o (grant),
    .idx_o   (gidx),
    .any_o   (any)
  );

  assign start_ret = (state_q == ST_IDLE) && reti_i;
  assign accept    = (state_q == ST_IDLE) && !reti_i && gie_q && any;
  assign push      = (state_q == ST_PUSH_LO) || (state_q == ST_PUSH_HI);
  assign pop       = (state_q == ST_POP_HI) || (state_q == ST_POP_LO);

  irq_entry_sp #(.AW(AW), .SP_INIT(SP_INIT)) u_sp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dec_i  (push),
    .inc_i  (pop),
    .sp_o   (sp)
  );

  always_comb begin
    vec_d = (AW'(BASE_SLOT) + AW'(gidx)) << 1;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_ret)   state_d = ST_POP_HI;
        else if (accept) state_d = ST_PUSH_LO;
      end
      ST_PUSH_LO: state_d = ST_PUSH_HI;
      ST_PUSH_HI: state_d = ST_CLR;
      ST_CLR:     state_d = ST_JMP_V;
      ST_JMP_V:   state_d = ST_IDLE;
      ST_POP_HI:  state_d = ST_POP_LO;
      ST_POP_LO:  state_d = ST_CAP_LO;
      ST_CAP_LO:  state_d = ST_JMP_R;
      ST_JMP_R:   state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      gie_q   <= 1'b0;
      ret_q   <= '0;
      vec_q   <= '0;
      grant_q <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        gie_q   <= 1'b0;
        ret_q   <= ret_pc_i;
        vec_q   <= vec_d;
        grant_q <= grant;
      end else if (state_q == ST_IDLE && !start_ret) begin
        if (sei_i)      gie_q <= 1'b1;
        else if (cli_i) gie_q <= 1'b0;
      end
      // read data lags the address by one cycle
      if (state_q == ST_POP_LO) hi_q <= stk_rdata_i;
      if (state_q == ST_CAP_LO) lo_q <= stk_rdata_i;
      if (state_q == ST_JMP_R)  gie_q <= 1'b1;
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign gie_o       = gie_q;
  assign stk_we_o    = push;
  assign stk_wdata_o = (state_q == ST_PUSH_LO) ? ret_q[DW-1:0] : ret_q[AW-1:DW];
  assign stk_addr_o  = pop ? sp + AW'(1) : sp;
  assign flag_clr_o  = (state_q == ST_CLR) ? grant_q : '0;
  assign pc_load_o   = (state_q == ST_JMP_V) || (state_q == ST_JMP_R);
  assign pc_o        = (state_q == ST_JMP_R) ? {hi_q, lo_q} : vec_q;
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk
  import irq_entry_pkg::*;
#(
  parameter int N_SRC = 11,
  parameter int AW    = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             gie_o,
  input logic             stk_we_o,
  input logic [AW-1:0]    stk_addr_o,
  input logic             pc_load_o,
  input logic [N_SRC-1:0] flag_clr_o,
  input seq_state_e       state_q
);
  // R6
  flag_clr_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(flag_clr_o));

  // R2
  entry_clears_gie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PUSH_LO) |-> !gie_o);

  // R5
  push_post_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PUSH_LO) |=> stk_we_o && (stk_addr_o == $past(stk_addr_o) - AW'(1)));

  // R7
  pop_pre_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_POP_HI) |=> (stk_addr_o == $past(stk_addr_o) + AW'(1)));

  // R7
  ret_sets_gie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_JMP_R) |=> gie_o);

  // R8
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> busy_o);

  // R8
  load_ends_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |=> !busy_o);
endmodule

bind irq_entry_ctrl irq_entry_chk #(.N_SRC(N_SRC), .AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .gie_o      (gie_o),
  .stk_we_o   (stk_we_o),
  .stk_addr_o (stk_addr_o),
  .pc_load_o  (pc_load_o),
  .flag_clr_o (flag_clr_o),
  .state_q    (state_q)
);

// File: tb/irq_entry_ctrl_bench.sv
`timescale 1ns/1ps
module irq_entry_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] flags = '0, en = '0, flag_clr;
  logic        sei = 0, cli = 0, reti = 0;
  logic [15:0] rpc = '0, pc, addr;
  logic        busy, gie, pc_load, we;
  logic [7:0]  wdata, rdata;
  logic [7:0]  mem [256];
  int          errs = 0, checks = 0, cyc = 0;

  always #2 clk = ~clk;

  irq_entry_ctrl u_irq_entry_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .src_flag_i(flags), .src_en_i(en),
    .sei_i(sei), .cli_i(cli), .reti_i(reti), .ret_pc_i(rpc),
    .busy_o(busy), .gie_o(gie), .flag_clr_o(flag_clr), .pc_load_o(pc_load),
    .pc_o(pc), .stk_addr_o(addr), .stk_wdata_o(wdata), .stk_we_o(we),
    .stk_rdata_i(rdata)
  );

  // stack model with registered read; peripheral drops a flag after its strobe
  always @(posedge clk) begin
    if (we) mem[addr[7:0]] <= wdata;
    rdata <= mem[addr[7:0]];
    flags <= flags & ~flag_clr;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: got %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic pulse_sei();
    @(negedge clk); sei = 1;
    @(negedge clk); sei = 0;
  endtask

  task automatic pulse_cli();
    @(negedge clk); cli = 1;
    @(negedge clk); cli = 0;
  endtask

  task automatic quiet(input int n, input string rq);
    int nb = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (busy) nb++;
    end
    chk(nb == 0, rq, nb, 0);
  endtask

  task automatic run_entry(input logic [10:0] f, input logic [10:0] e,
                           input logic [15:0] ra, input int idx);
    int nb = 0, nl = 0;
    logic [15:0] gp = '0;
    logic [10:0] clr = '0;
    logic [10:0] exp_left;
    @(negedge clk); flags = f; en = e; rpc = ra;
    exp_left = f & ~(11'(1) << idx);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (busy) nb++;
      if (pc_load) begin nl++; gp = pc; end
      if (flag_clr != 0) clr = flag_clr;
    end
    chk(nb == 4, "R8 entry busy cycles", nb, 4);
    chk(nl == 1, "R8 entry load count", nl, 1);
    chk(gp == 16'((9 + idx) * 2), "R3/R4 vector", gp, (9 + idx) * 2);
    chk(clr == (11'(1) << idx), "R6 clear strobe", clr, 1 << idx);
    chk(flags == exp_left, "R6 flag cleared", flags, exp_left);
    chk(mem[8'hFF] == ra[7:0], "R5 low byte at sp", mem[8'hFF], ra[7:0]);
    chk(mem[8'hFE] == ra[15:8], "R5 high byte at sp-1", mem[8'hFE], ra[15:8]);
    chk(!gie, "R2 gie cleared", gie, 0);
  endtask

  task automatic run_ret(input logic [15:0] ra);
    int nb = 0, nl = 0;
    logic [15:0] gp = '0;
    @(negedge clk); en = '0; reti = 1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      reti = 0;
      if (busy) nb++;
      if (pc_load) begin nl++; gp = pc; end
    end
    chk(nb == 4, "R8 return busy cycles", nb, 4);
    chk(nl == 1 && gp == ra, "R7 restored pc", gp, ra);
    chk(gie, "R7 gie set", gie, 1);
  endtask

  localparam logic [10:0] TF [6] = '{11'h001, 11'h400, 11'h0F0, 11'h401, 11'h7FF, 11'h240};
  localparam logic [10:0] TE [6] = '{11'h001, 11'h400, 11'h7FF, 11'h400, 11'h7FE, 11'h200};
  localparam int          TI [6] = '{0, 10, 4, 10, 1, 9};
  localparam logic [15:0] TP [6] = '{16'h1234, 16'hA55A, 16'h0F0E, 16'hBEEF, 16'h8001, 16'h00FF};

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errs++; checks++;
      $display("FAIL watchdog: got %0d expected below %0d cycles", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!busy && !gie && !we && !pc_load, "R9 reset outputs", {busy, gie, we, pc_load}, 0);
    chk(addr == 16'h10FF, "R9 reset sp", addr, 16'h10FF);
    rst_n = 1;
    // R2: a request is ignored while gie is 0
    @(negedge clk); flags = 11'h001; en = 11'h001;
    quiet(6, "R2 no entry without gie");
    flags = '0; en = '0;
    // R10 sei/cli
    pulse_sei();
    chk(gie, "R10 sei sets gie", gie, 1);
    pulse_cli();
    chk(!gie, "R10 cli clears gie", gie, 0);
    pulse_sei();
    // R1: a flag without enable, or an enable without flag, is ignored
    @(negedge clk); flags = 11'h004; en = 11'h003;
    quiet(6, "R1 no entry without both bits");
    chk(gie, "R1 gie untouched", gie, 1);
    flags = '0; en = '0;
    // table walk
    for (int r = 0; r < 6; r++) begin
      run_entry(TF[r], TE[r], TP[r], TI[r]);
      run_ret(TP[r]);
      flags = '0;
    end
    // R10: a return wins over a request in the same cycle
    @(negedge clk); flags = 11'h002; en = 11'h002; reti = 1;
    @(negedge clk); reti = 0;
    chk(busy && gie, "R10 return takes priority", {busy, gie}, 3);
    repeat (6) @(negedge clk);
    flags = '0; en = '0;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule